// File: doc/BRIEF.md
# Dual-Mode Countdown Timer

A memory-mapped countdown timer with a small register bus (byte address, write strobe, write data, registered read data) and one level-sensitive interrupt line. Software places a 64-bit start value in two 32-bit words and then writes a control word. The control word has three bits: one runs the counter, one chooses between automatic reload and a single count, and one lets the pending flag reach the interrupt pin.

Turning the run bit on from off copies the start value into the counter. The counter then steps down by one on every clock. When a running counter sits at zero, a terminal event fires. In reload mode the start value is copied back in, so events come every N+1 clocks. In single-count mode the counter stays at zero and fires nothing more until the run bit is switched off and on again. The hardware never clears the run bit itself. Each event sets a sticky pending flag, and software clears it by writing a one. The control word's offset is a build parameter, so two register-map variants come from one source.

Top module: `tmr_countdown`

## Requirements
- R1: After synchronous reset every register reads 0, the counter is 0 and `irq` is low.
- R2: Offset 0x00 holds bits 31:0 of the start value and 0x04 holds bits 63:32; both read back what was written.
- R3: A control write that sets bit 0 while it was 0 loads the counter from the start value on that edge. The counter then falls by one per clock, borrowing across the 32-bit boundary. A control write with bit 0 already set does not reload. The counter reads as bits 31:0 at 0x08 and bits 63:32 at 0x0C.
- R4: With bit 1 = 0 (reload mode), a running counter at zero fires an event and reloads, so events are N+1 clocks apart and the first comes N+1 clocks after the enabling write.
- R5: With bit 1 = 1 (single count), exactly one event fires N+1 clocks after the enabling write. The counter then holds at 0 and the control word still reads with bit 0 set.
- R6: Writing 0 to the control word freezes the counter, which then fires no events.
- R7: Bit 0 of the status word at 0x18 is set by every event, even while the interrupt is masked. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R8: If an event and a clear land on the same edge, the flag stays set.
- R9: `irq` equals the status flag ANDed with control bit 2, and follows either one on the same edge.
- R10: The control word lives at parameter `CTRL_OFS` (0x10 by default, 0x1C in the other variant). Writes at the other candidate offset have no effect.
- R11: Reads of offsets that map to no register return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the address of the previous cycle |
| irq | output | 1 | Level interrupt, pending flag gated by the unmask bit |

## Verification
A write takes effect on the next rising edge. Read data for an address shows up after the following edge and holds the register contents from just before that edge. The first terminal event lands N+1 edges after the enabling write edge. The status flag and `irq` change on that same edge. The bench drives and samples only on falling edges and counts the falling edges between the enabling write and the rise of `irq`, so each latency is checked against an exact edge count rather than a window. Counter reads are predicted by counting every edge, including the edges used by the reads themselves and by any write that stops the counter.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int unsigned OFS_LOAD  = 'h00;
  localparam int unsigned OFS_CNT   = 'h08;
  localparam int unsigned OFS_STAT  = 'h18;
  localparam int unsigned CTL_OFS_A = 'h10;
  localparam int unsigned CTL_OFS_B = 'h1C;
  localparam int          CTL_W     = 3;

  // bit 0 run, bit 1 single count, bit 2 unmask
  typedef struct packed {
    logic unmask;
    logic oneshot;
    logic en;
  } ctl_t;
endpackage

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             oneshot,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic [CNT_W-1:0] cnt,
  output logic             evt
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             zero;

  assign zero = (cnt_q == '0);
  assign evt  = en & zero & (~oneshot | ~done_q);
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= load;
      done_q <= 1'b0;
    end else if (en) begin
      if (zero) begin
        if (!oneshot) cnt_q <= load;
        else if (evt) done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  a_r3_load_on_start: assert property (@(posedge clk) disable iff (rst)
    start |=> cnt_q == $past(load));
  a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
    (en && !zero) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (en && !oneshot && zero) |=> cnt_q == $past(load));
  a_r5_hold_zero: assert property (@(posedge clk) disable iff (rst)
    (en && oneshot && zero) |=> cnt_q == '0);
  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    (!en && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs import tmr_pkg::*; #(
  parameter int          ADDR_W   = 5,
  parameter int          DATA_W   = 32,
  parameter int          WORDS    = 2,
  parameter int unsigned CTRL_OFS = CTL_OFS_A
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    we,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    evt,
  input  logic [DATA_W*WORDS-1:0] cnt,
  output logic [DATA_W*WORDS-1:0] load,
  output ctl_t                    ctl,
  output logic                    start,
  output logic [DATA_W-1:0]       rdata,
  output logic                    irq
);
  localparam int unsigned STRIDE = DATA_W / 8;

  logic [DATA_W-1:0] load_w [WORDS];
  ctl_t              ctl_q, ctl_d;
  logic              stat_q, stat_d;
  logic              ctl_wr, stat_clr;
  logic [DATA_W-1:0] rd_d;

  for (genvar g = 0; g < WORDS; g++) begin : g_load
    always_ff @(posedge clk) begin
      if (rst) load_w[g] <= '0;
      else if (we && addr == ADDR_W'(OFS_LOAD + STRIDE * g)) load_w[g] <= wdata;
    end
    assign load[g*DATA_W +: DATA_W] = load_w[g];
  end

  assign ctl_wr   = we && (addr == ADDR_W'(CTRL_OFS));
  assign stat_clr = we && (addr == ADDR_W'(OFS_STAT)) && wdata[0];
  assign ctl_d    = ctl_wr ? ctl_t'(wdata[CTL_W-1:0]) : ctl_q;
  assign start    = ctl_wr && wdata[0] && !ctl_q.en;
  assign stat_d   = evt | (stat_q & ~stat_clr);
  assign ctl      = ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      stat_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      stat_q <= stat_d;
      irq    <= stat_d & ctl_d.unmask;
    end
  end

  always_comb begin
    rd_d = '0;
    for (int k = 0; k < WORDS; k++) begin
      if (addr == ADDR_W'(OFS_LOAD + STRIDE * k)) rd_d = load_w[k];
      if (addr == ADDR_W'(OFS_CNT + STRIDE * k))  rd_d = cnt[k*DATA_W +: DATA_W];
    end
    if (addr == ADDR_W'(CTRL_OFS)) rd_d = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
    if (addr == ADDR_W'(OFS_STAT)) rd_d = {{(DATA_W-1){1'b0}}, stat_q};
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end

  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    evt |=> stat_q);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !evt) |=> !stat_q);
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (stat_q && !stat_clr) |=> stat_q);
  a_r9_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq == (stat_q & ctl_q.unmask));
endmodule

// File: rtl/tmr_countdown.sv
`timescale 1ns/1ps
module tmr_countdown import tmr_pkg::*; #(
  parameter int          ADDR_W   = 5,
  parameter int          DATA_W   = 32,
  parameter int          WORDS    = 2,
  parameter int unsigned CTRL_OFS = CTL_OFS_A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = DATA_W * WORDS;

  logic [CNT_W-1:0] load, cnt;
  ctl_t             ctl;
  logic             start, evt;

  tmr_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .CTRL_OFS(CTRL_OFS)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .evt(evt), .cnt(cnt), .load(load), .ctl(ctl), .start(start),
    .rdata(bus_rdata), .irq(irq)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .en(ctl.en), .oneshot(ctl.oneshot), .start(start),
    .load(load), .cnt(cnt), .evt(evt)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!irq && bus_rdata == '0));
endmodule

// File: tb/sim_tmr_countdown.sv
`timescale 1ns/1ps
module sim_tmr_countdown;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        irq0, irq1;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  tmr_countdown u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata0), .irq(irq0)
  );
  tmr_countdown #(.CTRL_OFS('h1C)) u1 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata1), .irq(irq1)
  );

  // {single-count mode, start value}
  localparam logic [32:0] VEC [6] = '{
    {1'b0, 32'd1}, {1'b0, 32'd4}, {1'b0, 32'd9},
    {1'b1, 32'd0}, {1'b1, 32'd3}, {1'b1, 32'd7}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d0, output logic [31:0] d1);
    addr = a; we = 1'b0;
    @(negedge clk);
    d0 = rdata0; d1 = rdata1;
  endtask

  task automatic wait_irq(input bit sel, output int c);
    c = 0;
    while (c < 300) begin
      @(negedge clk);
      c++;
      if (sel ? irq1 : irq0) break;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r0, r1, frz;
    int c, c2;
    bit seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq u0", irq0, 0);
    chk("R1 irq u1", irq1, 0);
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), r0, r1);
      chk("R1 reset read u0", r0, 0);
      chk("R1 reset read u1", r1, 0);
    end

    // R2 start value words
    wr(5'h00, 32'hA5A5_0001);
    wr(5'h04, 32'h0000_0007);
    rd(5'h00, r0, r1); chk("R2 low word", r0, 32'hA5A5_0001);
    rd(5'h04, r0, r1); chk("R2 high word", r0, 32'h0000_0007);
    wr(5'h04, 32'h0);

    // R4 / R5 vector table
    for (int i = 0; i < 6; i++) begin
      logic        mode;
      logic [31:0] n;
      mode = VEC[i][32];
      n    = VEC[i][31:0];
      wr(5'h10, 32'h0);
      wr(5'h18, 32'h1);
      wr(5'h00, n);
      wr(5'h10, {29'b0, 1'b1, mode, 1'b1});
      wait_irq(1'b0, c);
      chk(mode ? "R5 first event latency" : "R4 first event latency", 64'(c), 64'(n) + 1);
      if (!mode) begin
        wr(5'h18, 32'h1);
        wait_irq(1'b0, c2);
        chk("R4 reload period", 64'(c2 + 1), 64'(n) + 1);
      end else begin
        rd(5'h08, r0, r1); chk("R5 counter holds zero", r0, 0);
        rd(5'h10, r0, r1); chk("R5 run bit stays set", r0, 32'h7);
        wr(5'h18, 32'h1);
        seen = 1'b0;
        for (int k = 0; k < 2 * int'(n) + 4; k++) begin
          @(negedge clk);
          if (irq0) seen = 1'b1;
        end
        chk("R5 no second event", 64'(seen), 0);
      end
    end
    wr(5'h10, 32'h0);
    wr(5'h18, 32'h1);

    // R3 load, borrow across words, readout; R6 freeze
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h5);
    wr(5'h10, 32'h1);
    rd(5'h0C, r0, r1); chk("R3 high count word", r0, 32'h5);
    rd(5'h08, r0, r1); chk("R3 borrow low word", r0, 32'hFFFF_FFFF);
    rd(5'h0C, r0, r1); chk("R3 borrow high word", r0, 32'h4);
    wr(5'h10, 32'h0);
    rd(5'h08, r0, r1); chk("R6 frozen value", r0, 32'hFFFF_FFFC);
    frz = r0;
    repeat (5) @(negedge clk);
    rd(5'h08, r0, r1); chk("R6 still frozen", r0, frz);
    chk("R6 no event while stopped", irq0, 0);

    // R3 reload on rising run bit, no reload when already running
    wr(5'h00, 32'd20);
    wr(5'h04, 32'h0);
    wr(5'h10, 32'h1);
    rd(5'h08, r0, r1); chk("R3 reload on enable", r0, 32'd20);
    rd(5'h08, r0, r1); chk("R3 one step per clock", r0, 32'd19);
    wr(5'h10, 32'h1);
    rd(5'h08, r0, r1); chk("R3 no reload while running", r0, 32'd17);
    wr(5'h10, 32'h0);
    wr(5'h18, 32'h1);

    // R7 masked event, write-0 ignored, R9 gating
    wr(5'h00, 32'd2);
    wr(5'h10, 32'h1);
    seen = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (irq0) seen = 1'b1;
    end
    chk("R9 masked irq stays low", 64'(seen), 0);
    rd(5'h18, r0, r1); chk("R7 flag set while masked", r0, 32'h1);
    wr(5'h10, 32'h0);
    wr(5'h18, 32'h0);
    rd(5'h18, r0, r1); chk("R7 write 0 ignored", r0, 32'h1);
    wr(5'h10, 32'h4);
    chk("R9 unmask raises irq", irq0, 1);
    wr(5'h10, 32'h0);
    chk("R9 mask drops irq", irq0, 0);
    wr(5'h18, 32'h1);
    rd(5'h18, r0, r1); chk("R7 write 1 clears", r0, 32'h0);

    // R8 event every clock beats the clear
    wr(5'h00, 32'h0);
    wr(5'h10, 32'h5);
    wr(5'h18, 32'h1);
    chk("R8 irq held", irq0, 1);
    rd(5'h18, r0, r1); chk("R8 set wins", r0, 32'h1);
    wr(5'h10, 32'h0);
    wr(5'h18, 32'h1);
    rd(5'h18, r0, r1); chk("R7 cleared after stop", r0, 32'h0);
    chk("R9 irq low after clear", irq0, 0);

    // R10 / R11 control offset variant
    wr(5'h00, 32'd2);
    wr(5'h1C, 32'h5);
    wait_irq(1'b1, c);
    chk("R10 variant event latency", 64'(c), 3);
    chk("R10 default ignores 0x1C", irq0, 0);
    rd(5'h1C, r0, r1);
    chk("R11 unmapped 0x1C reads 0", r0, 0);
    chk("R10 variant control at 0x1C", r1, 32'h5);
    rd(5'h10, r0, r1);
    chk("R11 variant 0x10 reads 0", r1, 0);
    rd(5'h14, r0, r1);
    chk("R11 0x14 reads 0", r0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule